// File: doc/BRIEF.md
# Message Character Count Tracker

This block keeps track of message lengths for one synchronous serial channel. On the receive side it counts the characters of each incoming message. When a message ends, it stores the length in a small first-in first-out queue of lengths. A host that moves the received data by DMA pops these lengths later, so it can tell where one message stops and the next starts in memory.

On the transmit side it holds a down-counter of characters still to be written into the transmit data FIFO. A mode input selects how the counter is loaded. In direct mode, a configuration write loads it. In preset mode, the write only stores a preset value, and the counter takes that value when a transmit message starts. Once the counter has run down to zero, the block waits for the shifter to report that the final counted byte has left. It then pulses a termination request so the framer can close the message.

Top module: `msg_len_tracker`

## Requirements
- R1: `rx_som_i` clears the receive count. A `rx_char_i` strobe in the same cycle counts as the first character of the new message. Every other `rx_char_i` strobe adds one. `rx_eom_i` pushes the count, including a character strobed in that same cycle, into the length queue.
- R2: The receive count saturates at 2^CNT_W-1 and never wraps to zero.
- R3: The length queue holds DEPTH entries (4 by default) in arrival order. A `len_rd_i` strobe pops the oldest entry onto `len_data_o` in the next cycle. `len_nempty_o` is high while the queue holds at least one entry.
- R4: A `len_rd_i` strobe while the queue is empty drives 0 onto `len_data_o` and leaves the queue empty.
- R5: A push that finds the queue full is dropped, even if a pop happens in the same cycle. It sets `len_ovf_o`, which stays high until a `len_ovf_clr_i` strobe. A new overflow in the clear cycle wins over the clear.
- R6: With `tx_preset_mode_i`=0, a `tx_cfg_wr_i` write loads `tx_cfg_data_i` into the transmit counter. The new value shows on `tx_count_o` one cycle later.
- R7: With `tx_preset_mode_i`=1, a `tx_cfg_wr_i` write stores the preset only and leaves `tx_count_o` unchanged. `tx_som_i` then loads the preset into the counter.
- R8: Each `tx_fifo_wr_i` strobe lowers a nonzero transmit count by one. At zero, the count stays at zero.
- R9: `tx_term_o` is high for exactly one cycle, one cycle after the `tx_byte_sent_i` strobe that retires the last outstanding counted byte. It pulses at most once per load, and never for a load of zero.
- R10: After reset, the counts, `len_data_o`, `len_nempty_o`, `len_ovf_o` and `tx_term_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_som_i | input | 1 | Start of received message |
| rx_char_i | input | 1 | One received character |
| rx_eom_i | input | 1 | End of received message |
| len_rd_i | input | 1 | Pop strobe for the length queue |
| len_data_o | output | CNT_W | Popped message length |
| len_nempty_o | output | 1 | Length queue holds an entry |
| len_ovf_o | output | 1 | Sticky dropped-length flag |
| len_ovf_clr_i | input | 1 | Clears the dropped-length flag |
| tx_preset_mode_i | input | 1 | 1: load at message start, 0: load on write |
| tx_cfg_wr_i | input | 1 | Configuration write strobe |
| tx_cfg_data_i | input | CNT_W | Configuration write data |
| tx_som_i | input | 1 | Start of transmit message |
| tx_fifo_wr_i | input | 1 | Write into transmit data FIFO |
| tx_byte_sent_i | input | 1 | Shifter finished one byte |
| tx_count_o | output | CNT_W | Remaining transmit count |
| tx_term_o | output | 1 | One-cycle termination request |

## Verification
A bad receive count shows as a wrong length at the very next pop, and that pop can come many messages later. So the bench pops and compares each length as a scoreboard entry. Bad queue pointers or a bad occupancy count reorder or lose entries. This shows up as a wrong value, as `len_nempty_o` staying high one entry too long or dropping one entry too soon, or as an overflow flag that is wrong after the fifth push. A bad transmit in-flight count moves `tx_term_o` by at least one byte-sent strobe, or repeats it. The bench therefore checks the pulse in the cycle that follows each sent byte.

// File: rtl/msg_len_pkg.sv
package msg_len_pkg;
  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/rx_len_count.sv
module rx_len_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         som,
  input  logic         chr,
  input  logic         eom,
  output logic         push,
  output logic [W-1:0] push_val
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt;
  logic [W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = (cnt == MAXV) ? cnt : cnt + 1'b1;
    push    = eom;
    if (som)      push_val = cnt;
    else if (chr) push_val = cnt_inc;
    else          push_val = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (som) cnt <= chr ? W'(1) : '0;
    else if (chr) cnt <= cnt_inc;
  end

  a_r2_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAXV && chr && !som) |=> (cnt == MAXV));
  a_r1_som_clear: assert property (@(posedge clk) disable iff (rst)
    (som && !chr) |=> (cnt == '0));
endmodule

// File: rtl/len_fifo.sv
module len_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         rd,
  output logic [W-1:0] dout,
  output logic         nempty,
  output logic         ovf,
  input  logic         ovf_clr
);
  localparam int AW = msg_len_pkg::ptr_bits(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, empty, do_push, do_pop, drop;

  always_comb begin
    full    = (count == CW'(DEPTH));
    empty   = (count == '0);
    do_push = push && !full;
    drop    = push && full;
    do_pop  = rd && !empty;
    nempty  = !empty;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)            dout <= '0;
    else if (do_pop)    dout <= mem[rd_ptr];
    else if (rd)        dout <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  a_r3_depth_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r4_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd && empty && !push) |=> (dout == '0 && count == '0));
  a_r5_drop_flags: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ovf);
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/tx_len_count.sv
module tx_len_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         preset_mode,
  input  logic         cfg_wr,
  input  logic [W-1:0] cfg_data,
  input  logic         som,
  input  logic         fifo_wr,
  input  logic         byte_sent,
  output logic [W-1:0] count,
  output logic         term
);
  logic [W-1:0] preset;
  logic [W-1:0] inflight;
  logic         pend;
  logic         load_now, cnt_wr, retire;
  logic [W-1:0] load_val;

  always_comb begin
    load_now = (cfg_wr && !preset_mode) || (som && preset_mode);
    load_val = preset_mode ? preset : cfg_data;
    cnt_wr   = fifo_wr && (count != '0) && !load_now;
    retire   = byte_sent && (inflight != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preset   <= '0;
      count    <= '0;
      inflight <= '0;
      pend     <= 1'b0;
      term     <= 1'b0;
    end else begin
      term <= 1'b0;
      if (preset_mode && cfg_wr) preset <= cfg_data;
      if (load_now) begin
        count    <= load_val;
        inflight <= '0;
        pend     <= 1'b0;
      end else begin
        if (cnt_wr) count <= count - 1'b1;
        case ({cnt_wr, retire})
          2'b10:   inflight <= inflight + 1'b1;
          2'b01:   inflight <= inflight - 1'b1;
          default: inflight <= inflight;
        endcase
        if (cnt_wr && count == W'(1)) pend <= 1'b1;
        if (pend && retire && inflight == W'(1) && !cnt_wr) begin
          term <= 1'b1;
          pend <= 1'b0;
        end
      end
    end
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    term |=> !term);
  a_r8_hold_zero: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && fifo_wr && !cfg_wr && !som) |=> (count == '0));
  a_r6_direct_load: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !preset_mode) |=> (count == $past(cfg_data)));
  a_r9_needs_sent: assert property (@(posedge clk) disable iff (rst)
    $rose(term) |-> $past(byte_sent));
endmodule

// File: rtl/msg_len_tracker.sv
module msg_len_tracker #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_som_i,
  input  logic             rx_char_i,
  input  logic             rx_eom_i,
  input  logic             len_rd_i,
  output logic [CNT_W-1:0] len_data_o,
  output logic             len_nempty_o,
  output logic             len_ovf_o,
  input  logic             len_ovf_clr_i,
  input  logic             tx_preset_mode_i,
  input  logic             tx_cfg_wr_i,
  input  logic [CNT_W-1:0] tx_cfg_data_i,
  input  logic             tx_som_i,
  input  logic             tx_fifo_wr_i,
  input  logic             tx_byte_sent_i,
  output logic [CNT_W-1:0] tx_count_o,
  output logic             tx_term_o
);
  logic             rx_push;
  logic [CNT_W-1:0] rx_val;

  rx_len_count #(.W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .som(rx_som_i), .chr(rx_char_i), .eom(rx_eom_i),
    .push(rx_push), .push_val(rx_val)
  );

  len_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_val), .rd(len_rd_i),
    .dout(len_data_o), .nempty(len_nempty_o), .ovf(len_ovf_o),
    .ovf_clr(len_ovf_clr_i)
  );

  tx_len_count #(.W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .preset_mode(tx_preset_mode_i), .cfg_wr(tx_cfg_wr_i),
    .cfg_data(tx_cfg_data_i), .som(tx_som_i), .fifo_wr(tx_fifo_wr_i),
    .byte_sent(tx_byte_sent_i), .count(tx_count_o), .term(tx_term_o)
  );
endmodule

// File: tb/test_msg_len_tracker.sv
module test_msg_len_tracker;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_som = 0, rx_char = 0, rx_eom = 0, len_rd = 0, ovf_clr = 0;
  logic pmode = 0, cfg_wr = 0, tx_som = 0, fwr = 0, sent = 0;
  logic [W-1:0] cfg_data = '0;
  logic [W-1:0] len_data, tx_count;
  logic nempty, ovf, term;
  int checks = 0, failures = 0;
  logic rd_q = 1'b0;
  logic [W-1:0] exp_q[$];

  always #10 clk = ~clk;

  msg_len_tracker #(.CNT_W(W), .DEPTH(4)) i_msg_len_tracker (
    .clk(clk), .rst(rst), .rx_som_i(rx_som), .rx_char_i(rx_char),
    .rx_eom_i(rx_eom), .len_rd_i(len_rd), .len_data_o(len_data),
    .len_nempty_o(nempty), .len_ovf_o(ovf), .len_ovf_clr_i(ovf_clr),
    .tx_preset_mode_i(pmode), .tx_cfg_wr_i(cfg_wr), .tx_cfg_data_i(cfg_data),
    .tx_som_i(tx_som), .tx_fifo_wr_i(fwr), .tx_byte_sent_i(sent),
    .tx_count_o(tx_count), .tx_term_o(term)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // scoreboard monitor: compares each popped length
  always @(posedge clk) rd_q <= len_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() > 0) check("R3 pop order", int'(len_data), int'(exp_q.pop_front()));
      else check("R4 empty read", int'(len_data), 0);
    end
  end

  // driver: one receive message; model decides push or overflow
  task automatic rx_msg(input int n, input bit last_chr, output bit dropped);
    int e;
    rx_som = 1; tick(); rx_som = 0;
    for (int i = 0; i < n; i++) begin rx_char = 1; tick(); end
    rx_char = last_chr; rx_eom = 1; tick(); rx_char = 0; rx_eom = 0;
    e = n + int'(last_chr);
    if (e > 255) e = 255;
    dropped = (exp_q.size() >= 4);
    if (!dropped) exp_q.push_back(W'(e));
  endtask

  task automatic pop();
    len_rd = 1; tick(); len_rd = 0;
  endtask

  task automatic cfg(input int v);
    cfg_data = W'(v); cfg_wr = 1; tick(); cfg_wr = 0;
  endtask

  task automatic txw();
    fwr = 1; tick(); fwr = 0;
  endtask

  task automatic txs();
    sent = 1; tick(); sent = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit d;
    repeat (3) tick();
    rst = 0; tick();
    // R10 reset state
    check("R10 len_data", int'(len_data), 0);
    check("R10 nempty", int'(nempty), 0);
    check("R10 ovf", int'(ovf), 0);
    check("R10 term", int'(term), 0);
    check("R10 tx_count", int'(tx_count), 0);

    // R1 counting with and without a char in the eom cycle
    rx_msg(5, 1, d);
    rx_msg(3, 0, d);
    check("R3 nempty", int'(nempty), 1);
    pop(); pop(); tick();
    check("R3 nempty after drain", int'(nempty), 0);
    // R4 read while empty
    pop(); tick();
    check("R4 nempty stays 0", int'(nempty), 0);
    // R1 char on som cycle starts new message
    rx_som = 1; rx_char = 1; tick(); rx_som = 0;
    rx_eom = 1; tick(); rx_char = 0; rx_eom = 0;
    exp_q.push_back(W'(2));
    pop(); tick();

    // R5 fill then overflow
    for (int k = 1; k <= 4; k++) rx_msg(k, 0, d);
    check("R5 no ovf at full", int'(ovf), 0);
    rx_msg(9, 0, d);
    check("R5 model drop", int'(d), 1);
    check("R5 ovf set", int'(ovf), 1);
    for (int k = 0; k < 4; k++) pop();
    tick();
    check("R3 drained", int'(nempty), 0);
    check("R5 ovf sticky", int'(ovf), 1);
    ovf_clr = 1; tick(); ovf_clr = 0;
    check("R5 ovf cleared", int'(ovf), 0);

    // R2 saturation
    rx_msg(300, 1, d);
    pop(); tick();

    // R6 direct load, R8 decrement and hold, R9 term timing
    pmode = 0;
    cfg(3);
    check("R6 direct load", int'(tx_count), 3);
    txw(); check("R8 dec", int'(tx_count), 2);
    txw(); txw();
    check("R8 at zero", int'(tx_count), 0);
    txw();
    check("R8 no wrap", int'(tx_count), 0);
    txs(); check("R9 no early term 1", int'(term), 0);
    txs(); check("R9 no early term 2", int'(term), 0);
    sent = 1; tick(); sent = 0;
    // sent sampled at the edge before this negedge; term registered at it
    check("R9 term pulse", int'(term), 1);
    tick();
    check("R9 one cycle", int'(term), 0);
    txs(); check("R9 once per load", int'(term), 0);

    // R7 preset mode
    pmode = 1;
    cfg(2);
    check("R7 write does not load", int'(tx_count), 0);
    tx_som = 1; tick(); tx_som = 0;
    check("R7 som loads preset", int'(tx_count), 2);
    txw(); txs();
    check("R9 not yet", int'(term), 0);
    txw(); sent = 1; tick(); sent = 0;
    check("R9 preset-mode term", int'(term), 1);
    tick();

    // R9 zero load never terminates
    pmode = 0;
    cfg(0);
    txw(); txs(); tick();
    check("R9 zero load", int'(term), 0);
    check("R8 zero load count", int'(tx_count), 0);

    tick();
    check("R3 scoreboard empty", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule